// File: doc/BRIEF.md
# GHASH Multiply-Add Unit

This block performs one step of the GHASH chain used in authenticated encryption. It takes the running partial hash Y, one ciphertext block X and the hash subkey H, each 128 bits wide, and returns the next partial hash (Y xor X)·H over GF(2^128). Each operand travels as four 32-bit words concatenated into one bus. The block accepts operands in memory byte order and returns the result in the same order.

A caller pulses `start` while the unit is idle. The operands are captured on that edge. A bit-serial shift-and-add multiplier then consumes one coefficient of (Y xor X) per clock, and it folds any overflow back with the field polynomial. When the last step is done, `done` pulses for one cycle. The result stays on `resultOut` until the next accepted start.

Top module: `ghash_mul_add`

## Requirements
- R1: `resultOut` equals (Y xor X)·H in GF(2^128), with the operand and result encoding that R3 defines.
- R2: The product is reduced modulo u^128 + u^7 + u^2 + u + 1. For example, u^127·u gives u^7 + u^2 + u + 1.
- R3: Word i is bits [32i+31:32i] of a bus, and byte k is bits [8k+7:8k]. Coefficient of u^j is held in byte j/8 at bit 7-(j mod 8). So u^0 is bit 7 of byte 0 (value 128'h80), and u^127 is bit 0 of byte 15.
- R4: `done` is high for exactly one cycle. It first appears 128 rising edges after the edge that accepts `start`.
- R5: `busy` is high from the accepting edge until `done` rises. `busy` and `done` are never high together.
- R6: A `start` while `busy` is high is ignored. It changes neither the result nor the number of `done` pulses.
- R7: The operands are sampled only on the accepting edge. Changes on `yIn`, `xIn` and `hIn` afterwards have no effect on the result.
- R8: After `done`, `resultOut` holds its value until the next accepted start.
- R9: After reset, `busy` and `done` are low and `resultOut` is zero.
- R10: H = 0 gives a zero result. H = 128'h80 (the unit polynomial) gives Y xor X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request one multiply-add; accepted when not busy |
| yIn | input | 128 | Current partial hash, four 32-bit words |
| xIn | input | 128 | Ciphertext block, four 32-bit words |
| hIn | input | 128 | Hash subkey, four 32-bit words |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse: result ready |
| resultOut | output | 128 | Next partial hash, four 32-bit words |

## Verification
Faults in the shifting multiplicand or in the reduction fold only reach the ports once `done` rises. They then appear as a wrong `resultOut`. The bench therefore pairs operands that exercise each fold path (u^127·u, the unit polynomial, zero) with random vectors against a schoolbook model.

A wrong step counter or state shows within one operation in two ways. The latency count differs from 128, or `busy` and `done` overlap. A datapath that re-samples its inputs shows as a wrong result after the bench scrambles the input buses mid-run. A start that is not blocked while busy shows as an extra `done` pulse that finds an empty scoreboard.

// File: rtl/ghash_pkg.sv
package ghash_pkg;
  localparam int BLK_W = 128;
  localparam int WORD_W = 32;
  localparam int NUM_WORDS = BLK_W / WORD_W;
  localparam int CNT_W = $clog2(BLK_W);
  // low-order terms of the field polynomial (u^7 + u^2 + u + 1)
  localparam logic [7:0] RED_LOW = 8'h87;

  typedef struct packed {
    logic load;
    logic step;
  } dpCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ctlState_t;
endpackage

// File: rtl/ghash_brev8.sv
module ghash_brev8 #(
  parameter int W = 128
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NBYTES = W / 8;
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    for (genvar k = 0; k < 8; k++) begin : g_bit
      assign dout[8*b+k] = din[8*b+7-k];
    end
  end
endmodule

// File: rtl/ghash_ctrl.sv
module ghash_ctrl
  import ghash_pkg::*;
#(
  parameter int STEPS = BLK_W
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   done
);
  localparam int CW = $clog2(STEPS);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  ctlState_t state, stateNext;
  logic [CW-1:0] cnt;

  always_comb begin
    stateNext = state;
    ctl = '0;
    unique case (state)
      ST_RUN: begin
        ctl.step = 1'b1;
        if (cnt == LAST) stateNext = ST_DONE;
      end
      default: begin
        if (start) begin
          ctl.load = 1'b1;
          stateNext = ST_RUN;
        end else begin
          stateNext = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt <= '0;
    end else begin
      state <= stateNext;
      if (ctl.load) cnt <= '0;
      else if (ctl.step) cnt <= cnt + 1'b1;
    end
  end

  assign busy = (state == ST_RUN);
  assign done = (state == ST_DONE);

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R4
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy)); // R4
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != LAST) |=> busy); // R6
endmodule

// File: rtl/ghash_dp.sv
module ghash_dp
  import ghash_pkg::*;
#(
  parameter int W = BLK_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpCtl_t       ctl,
  input  logic [W-1:0] yIn,
  input  logic [W-1:0] xIn,
  input  logic [W-1:0] hIn,
  output logic [W-1:0] resultOut
);
  localparam logic [W-1:0] RED_POLY = {{(W-8){1'b0}}, RED_LOW};

  logic [W-1:0] sumMem, sumStd, hStd;
  logic [W-1:0] aReg, vReg, zReg, vNext;

  assign sumMem = yIn ^ xIn;

  ghash_brev8 #(.W(W)) u_sumSwap (.din(sumMem), .dout(sumStd));
  ghash_brev8 #(.W(W)) u_keySwap (.din(hIn),    .dout(hStd));
  ghash_brev8 #(.W(W)) u_outSwap (.din(zReg),   .dout(resultOut));

  // multiply the running multiplicand by u, folding u^128 back into the low terms
  assign vNext = {vReg[W-2:0], 1'b0} ^ (vReg[W-1] ? RED_POLY : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg <= '0;
      vReg <= '0;
      zReg <= '0;
    end else if (ctl.load) begin
      aReg <= sumStd;
      vReg <= hStd;
      zReg <= '0;
    end else if (ctl.step) begin
      if (aReg[0]) zReg <= zReg ^ vReg;
      vReg <= vNext;
      aReg <= aReg >> 1;
    end
  end

  AST_NO_LOAD_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.load && ctl.step)); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.step) |=> $stable(resultOut)); // R8
  AST_MULT_DRAINED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctl.step) |-> (aReg == '0)); // R1
endmodule

// File: rtl/ghash_mul_add.sv
module ghash_mul_add
  import ghash_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [BLK_W-1:0] yIn,
  input  logic [BLK_W-1:0] xIn,
  input  logic [BLK_W-1:0] hIn,
  output logic             busy,
  output logic             done,
  output logic [BLK_W-1:0] resultOut
);
  dpCtl_t ctl;

  ghash_ctrl #(.STEPS(BLK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .ctl(ctl), .busy(busy), .done(done)
  );

  ghash_dp #(.W(BLK_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .yIn(yIn), .xIn(xIn), .hIn(hIn),
    .resultOut(resultOut)
  );
endmodule

// File: tb/sim_ghash_mul_add.sv
module sim_ghash_mul_add;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [127:0] yIn = '0, xIn = '0, hIn = '0;
  logic busy, done;
  logic [127:0] resultOut;

  int checks = 0;
  int fails = 0;
  logic [127:0] expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ghash_mul_add u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .yIn(yIn), .xIn(xIn), .hIn(hIn),
    .busy(busy), .done(done), .resultOut(resultOut)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  function automatic int memPos(int j);
    return 8 * (j / 8) + 7 - (j % 8);
  endfunction

  // schoolbook product followed by explicit reduction
  function automatic logic [127:0] model(logic [127:0] y, logic [127:0] x, logic [127:0] h);
    logic [127:0] a;
    logic [254:0] prod;
    logic [127:0] r;
    a = y ^ x;
    prod = '0;
    for (int i = 0; i < 128; i++)
      for (int j = 0; j < 128; j++)
        prod[i+j] ^= a[memPos(i)] & h[memPos(j)];
    for (int d = 254; d >= 128; d--) begin
      if (prod[d]) begin
        prod[d] = 1'b0;
        prod[d-121] ^= 1'b1;
        prod[d-126] ^= 1'b1;
        prod[d-127] ^= 1'b1;
        prod[d-128] ^= 1'b1;
      end
    end
    r = '0;
    for (int j = 0; j < 128; j++) r[memPos(j)] = prod[j];
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // scoreboard monitor: R1 R6
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R6 unexpected done", resultOut, '0);
      end else begin
        logic [127:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(resultOut == e, t, resultOut, e);
      end
    end
  end

  task automatic runOp(input logic [127:0] y, input logic [127:0] x, input logic [127:0] h,
                       input string tag, input bit interfere);
    int n;
    logic [127:0] e;
    e = model(y, x, h);
    @(negedge clk);
    while (busy) @(negedge clk);
    yIn = y; xIn = x; hIn = h; start = 1'b1;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    yIn = rnd128(); xIn = rnd128(); hIn = rnd128(); // R7 scramble after capture
    n = 0;
    while (1) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (done) break;
      if (n > 200) break;
      if (!busy) chk(1'b0, "R5 busy dropped", 128'(busy), 128'd1);
      if (interfere && n == 50) begin
        start = 1'b1; yIn = rnd128(); xIn = rnd128(); hIn = rnd128(); // R6
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk(n == 128, "R4 latency", 128'(n), 128'd128);
    chk(!busy, "R5 busy with done", 128'(busy), 128'd0);
    @(negedge clk);
    chk(!done, "R4 done width", 128'(done), 128'd0);
    repeat (3) @(negedge clk);
    chk(resultOut == e, "R8 result held", resultOut, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R4 watchdog expired", '0, 128'd1);
    finishRun();
  end

  initial begin
    logic [127:0] y, x;
    repeat (3) @(negedge clk);
    chk(!busy && !done && resultOut == '0, "R9 reset state",
        {busy, done, resultOut[125:0]}, '0);
    rstN = 1'b1;
    @(negedge clk);

    y = rnd128(); x = rnd128();
    runOp(y, x, '0, "R10 zero key", 1'b0);
    chk(resultOut == '0, "R10 zero key direct", resultOut, '0);
    runOp(y, x, 128'h80, "R10 unit key", 1'b0);
    chk(resultOut == (y ^ x), "R10 unit key direct", resultOut, y ^ x);

    runOp(128'h40, '0, 128'h40, "R3 u times u", 1'b0);
    chk(resultOut == 128'h20, "R3 u times u direct", resultOut, 128'h20);

    runOp(128'h01 << 120, '0, 128'h40, "R2 fold", 1'b0);
    chk(resultOut == 128'hE1, "R2 fold direct", resultOut, 128'hE1);

    runOp(rnd128(), rnd128(), rnd128(), "R6 start while busy", 1'b1);
    runOp(rnd128(), rnd128(), rnd128(), "R7 inputs scrambled", 1'b0);

    for (int i = 0; i < 6; i++)
      runOp(rnd128(), rnd128(), rnd128(), "R1 random", 1'b0);

    repeat (5) @(negedge clk);
    chk(expQ.size() == 0, "R6 pending results", 128'(expQ.size()), '0);
    finishRun();
  end
endmodule